// File: doc/BRIEF.md
# Parity Chain Board-Test Mode

This block gives a board tester a way to prove that every signal pin of a chip is soldered and reaches the core, using one observation pin and no host software. While test mode is active, the observation pin carries the odd parity of all participating pins. Flipping any single participating pin therefore flips the observation pin. A tester can walk the pins one by one and watch the output alternate.

Test mode is chosen by two strap levels taken at the rising edge of the active-low reset input. The two straps are the host interface's data bit 0 and its frame strobe. If both are low at that edge, the chip enters test mode. If either is high at a later rising edge, it leaves test mode. A power-on reset clears the mode at any time. In test mode the two straps are themselves part of the chain. Outside test mode the observation pin shows the normal functional value from a separate input, and the chain has no effect on it.

Top module: `parity_chain_test`

## Requirements
- R1: On a low-to-high edge of `pci_rst_n` with `por` low, if `strap_data0` and `strap_frame_n` are both 0, `test_mode` becomes 1.
- R2: On a low-to-high edge of `pci_rst_n` with `por` low, if `strap_data0` or `strap_frame_n` is 1, `test_mode` becomes 0.
- R3: While `por` is 1, `test_mode` is 0 at once, and rising edges of `pci_rst_n` do not set it.
- R4: While `test_mode` is 1, `chain_out` equals the XOR of all N_CHAIN chain inputs. The chain inputs are `chain_pins` bits 0..N_CHAIN-3, then `strap_data0` at index N_CHAIN-2, then `strap_frame_n` at index N_CHAIN-1. Any single input flip toggles `chain_out`.
- R5: While `test_mode` is 1, a flip of `strap_data0` or `strap_frame_n` toggles `chain_out` and leaves `test_mode` unchanged.
- R6: In test mode, `chain_out` is 0 when every chain input is 0 and also when every chain input is 1. This holds because N_CHAIN is even (default 88).
- R7: While `test_mode` is 0, `chain_out` equals `func_val`, and changes on `chain_pins` or the straps have no effect on it.
- R8: `test_mode` changes only on a `pci_rst_n` rising edge or on `por`. Strap changes while `pci_rst_n` stays high or stays low leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por | input | 1 | Power-on reset, active high, asynchronous clear of the mode |
| pci_rst_n | input | 1 | Active-low system reset; its rising edge samples the straps |
| strap_data0 | input | 1 | Host data bit 0 level, used as a strap and as a chain input |
| strap_frame_n | input | 1 | Host frame strobe level, used as a strap and as a chain input |
| chain_pins | input | N_CHAIN-2 | All other participating input pins |
| func_val | input | 1 | Normal-function value for the observation pin |
| chain_out | output | 1 | Observation pin: parity in test mode, `func_val` otherwise |
| test_mode | output | 1 | 1 while the chip is in parity-chain test mode |

## Verification
The bench walks every chain input high in descending index order and then low in ascending order, straps included. It checks the exact parity and a toggle at each step. A dropped or duplicated tree leaf, or a strap left out of the chain, would break the alternation at one index. A leftover XNOR inversion would make the all-low or all-high end state read 1.

Mode control is exercised on both exit straps separately. Strap changes are tried with reset held low and held high, and the reset is raised while power-on reset is active. An edge-sensitivity error or a wrong AND/OR strap decode would leave the flag in the wrong state. The bench also toggles inputs out of test mode to catch a missing or inverted output mux.

// File: rtl/pct_pkg.sv
package pct_pkg;

  // Strap levels captured at the reset release edge
  typedef struct packed {
    logic frame_n;
    logic data0;
  } strap_t;

  // Entry is requested only when both straps sit low
  function automatic logic strap_requests_test(input strap_t s);
    return ~s.frame_n & ~s.data0;
  endfunction

endpackage

// File: rtl/pct_mode_latch.sv
module pct_mode_latch
  import pct_pkg::*;
(
  input  logic   por,
  input  logic   pci_rst_n,
  input  strap_t straps,
  output logic   mode_q
);

  // Edge of reset release decides the mode; power-on reset clears it
  always_ff @(posedge pci_rst_n or posedge por) begin
    if (por) mode_q <= 1'b0;
    else     mode_q <= strap_requests_test(straps);
  end

endmodule

// File: rtl/pct_xor_tree.sv
module pct_xor_tree #(
  parameter int WIDTH = 88
) (
  input  logic [WIDTH-1:0] vec,
  output logic             parity
);

  localparam int LEVELS = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam int PADW   = 1 << LEVELS;

  logic [PADW-1:0] padded;

  generate
    if (PADW > WIDTH) begin : g_pad
      assign padded = {{(PADW-WIDTH){1'b0}}, vec};
    end else begin : g_nopad
      assign padded = vec;
    end
  endgenerate

  // Balanced pairwise reduction, one level per generate step
  genvar l, k;
  generate
    for (l = 0; l <= LEVELS; l++) begin : g_lvl
      logic [(PADW>>l)-1:0] node;
      if (l == 0) begin : g_leaf
        assign node = padded;
      end else begin : g_red
        for (k = 0; k < (PADW >> l); k++) begin : g_pair
          assign node[k] = g_lvl[l-1].node[2*k] ^ g_lvl[l-1].node[2*k+1];
        end
      end
    end
  endgenerate

  assign parity = g_lvl[LEVELS].node[0];

endmodule

// File: rtl/pct_out_sel.sv
module pct_out_sel (
  input  logic mode,
  input  logic parity,
  input  logic func_val,
  output logic pin_val
);

  always_comb begin
    pin_val = mode ? parity : func_val;
  end

endmodule

// File: rtl/parity_chain_test.sv
module parity_chain_test
  import pct_pkg::*;
#(
  parameter int N_CHAIN = 88
) (
  input  logic               por,
  input  logic               pci_rst_n,
  input  logic               strap_data0,
  input  logic               strap_frame_n,
  input  logic [N_CHAIN-3:0] chain_pins,
  input  logic               func_val,
  output logic               chain_out,
  output logic               test_mode
);

  localparam int N_PINS = N_CHAIN - 2;

  strap_t             straps;
  logic [N_CHAIN-1:0] chain_vec;
  logic               parity;
  logic               mode_q;

  assign straps.data0   = strap_data0;
  assign straps.frame_n = strap_frame_n;

  // Straps occupy the two top indices of the chain
  assign chain_vec = {strap_frame_n, strap_data0, chain_pins[N_PINS-1:0]};

  pct_mode_latch u_mode (
    .por       (por),
    .pci_rst_n (pci_rst_n),
    .straps    (straps),
    .mode_q    (mode_q)
  );

  pct_xor_tree #(.WIDTH(N_CHAIN)) u_tree (
    .vec    (chain_vec),
    .parity (parity)
  );

  pct_out_sel u_sel (
    .mode     (mode_q),
    .parity   (parity),
    .func_val (func_val),
    .pin_val  (chain_out)
  );

  assign test_mode = mode_q;

endmodule

// File: rtl/pct_checker.sv
module pct_checker #(
  parameter int N_CHAIN = 88
) (
  input logic               por,
  input logic               pci_rst_n,
  input logic               strap_data0,
  input logic               strap_frame_n,
  input logic [N_CHAIN-3:0] chain_pins,
  input logic               func_val,
  input logic               chain_out,
  input logic               test_mode
);

  // Reference for the mode, from the strap rules
  logic exp_mode;
  always_ff @(posedge pci_rst_n or posedge por) begin
    if (por) exp_mode <= 1'b0;
    else     exp_mode <= !(strap_data0 || strap_frame_n);
  end

  // R1 / R2 / R8: flag matches the strap rule once reset falls again
  always @(negedge pci_rst_n) begin
    if (!por && !$isunknown(exp_mode))
      a_r1_r2_mode_rule: assert (test_mode == exp_mode);
  end

  // R3: power-on reset leaves the mode cleared
  always @(negedge por) begin
    a_r3_por_clears: assert (test_mode == 1'b0);
  end

  always_comb begin
    if (!$isunknown(test_mode)) begin
      // R7: outside test mode the pin passes the functional value
      if (!test_mode)
        a_r7_func_pass: assert (chain_out == func_val);
      // R4: parity of the full chain including straps
      if (test_mode)
        a_r4_parity: assert (chain_out == (^{strap_frame_n, strap_data0, chain_pins}));
      // R6: all-low chain gives a low pin
      if (test_mode && !strap_data0 && !strap_frame_n && (chain_pins == '0))
        a_r6_all_low: assert (chain_out == 1'b0);
    end
  end

endmodule

bind parity_chain_test pct_checker #(.N_CHAIN(N_CHAIN)) chk_i (
  .por           (por),
  .pci_rst_n     (pci_rst_n),
  .strap_data0   (strap_data0),
  .strap_frame_n (strap_frame_n),
  .chain_pins    (chain_pins),
  .func_val      (func_val),
  .chain_out     (chain_out),
  .test_mode     (test_mode)
);

// File: tb/parity_chain_test_tb.sv
module parity_chain_test_tb_top;

  localparam int N_CHAIN = 88;
  localparam int N_PINS  = N_CHAIN - 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic               por = 1'b0;
  logic               pci_rst_n = 1'b0;
  logic [N_CHAIN-1:0] v = '0;
  logic               func_val = 1'b0;
  logic               chain_out, test_mode;

  int total = 0;
  int bad = 0;
  bit done = 0;

  parity_chain_test #(.N_CHAIN(N_CHAIN)) dut_i (
    .por           (por),
    .pci_rst_n     (pci_rst_n),
    .strap_data0   (v[N_PINS]),
    .strap_frame_n (v[N_PINS+1]),
    .chain_pins    (v[N_PINS-1:0]),
    .func_val      (func_val),
    .chain_out     (chain_out),
    .test_mode     (test_mode)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic rst_pulse();
    @(posedge clk); pci_rst_n = 1'b0;
    @(posedge clk); pci_rst_n = 1'b1;
    settle();
  endtask

  function automatic logic par(input logic [N_CHAIN-1:0] x);
    return logic'($countones(x) % 2);
  endfunction

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic prev;
    #1 por = 1'b1;
    settle();
    chk("R3 reset mode", test_mode, 1'b0);
    func_val = 1'b1; settle();
    chk("R7 reset func", chain_out, 1'b1);
    // R3: rising reset edge during por with straps low must not enter
    rst_pulse();
    chk("R3 edge under por", test_mode, 1'b0);
    @(posedge clk); por = 1'b0; func_val = 1'b0;
    // R1: entry
    rst_pulse();
    chk("R1 enter", test_mode, 1'b1);
    chk("R6 all low", chain_out, 1'b0);
    // R4/R5: descending high walk over all chain indices
    for (int i = N_CHAIN - 1; i >= 0; i--) begin
      prev = chain_out;
      @(posedge clk); v[i] = 1'b1; settle();
      chk(i >= N_PINS ? "R5 strap high step" : "R4 high step", chain_out, par(v));
      chk("R4 toggle", chain_out, ~prev);
    end
    chk("R6 all high", chain_out, 1'b0);
    chk("R5 mode kept", test_mode, 1'b1);
    // ascending low walk
    for (int i = 0; i < N_CHAIN; i++) begin
      prev = chain_out;
      @(posedge clk); v[i] = 1'b0; settle();
      chk(i >= N_PINS ? "R5 strap low step" : "R4 low step", chain_out, par(v));
      chk("R4 toggle", chain_out, ~prev);
    end
    chk("R6 all low end", chain_out, 1'b0);
    // R8: strap changes with reset low, then high, no edge
    @(posedge clk); pci_rst_n = 1'b0; v[N_PINS] = 1'b1; settle();
    chk("R8 low hold", test_mode, 1'b1);
    @(posedge clk); v[N_PINS] = 1'b0; settle();
    @(posedge clk); pci_rst_n = 1'b1; settle();
    chk("R8 re-edge low straps", test_mode, 1'b1);
    @(posedge clk); v[N_PINS+1] = 1'b1; settle();
    chk("R8 high hold", test_mode, 1'b1);
    // R2: exit via frame strap
    rst_pulse();
    chk("R2 exit frame", test_mode, 1'b0);
    // R7: inputs ignored outside mode
    for (int i = 0; i < N_CHAIN; i += 7) begin
      @(posedge clk); v[i] = ~v[i]; func_val = 1'b0; settle();
      chk("R7 ignore low", chain_out, 1'b0);
      @(posedge clk); func_val = 1'b1; settle();
      chk("R7 ignore high", chain_out, 1'b1);
    end
    // re-enter, exit via data strap
    @(posedge clk); v = '0; settle();
    rst_pulse();
    chk("R1 re-enter", test_mode, 1'b1);
    @(posedge clk); v[N_PINS] = 1'b1; settle();
    chk("R5 strap in chain", chain_out, 1'b1);
    rst_pulse();
    chk("R2 exit data", test_mode, 1'b0);
    chk("R7 after exit", chain_out, func_val);
    // R3: por clears mid test
    @(posedge clk); v = '0; settle();
    rst_pulse();
    chk("R1 enter again", test_mode, 1'b1);
    @(posedge clk); por = 1'b1; settle();
    chk("R3 por clear", test_mode, 1'b0);
    @(posedge clk); por = 1'b0; settle();
    chk("R3 stays clear", test_mode, 1'b0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule